// File: doc/BRIEF.md
# Self-Clearing Timed Pulse Outputs

This block drives three active-low control pins for a system board. Two of them emit a fixed-length low pulse each time a host sets a command bit. One pulse acts as a master reset for attached devices. The other discharges an external latch that holds a chassis-intrusion event. The third pin is a static, software-driven gate drive for an external power switch that bypasses the front-panel switch. In a real board all three would be open-drain; here each is a plain level where 0 means "pulling low".

Software writes command bits through a small register interface. Each command bit reads back as 1 while its pulse is running. The hardware clears it when the minimum low time has passed. The reset pulse also needs an arming bit in a separate register. If software requests a reset while the arming bit is clear, the request is dropped and the command bit clears on its own within two cycles. The pulse length is counted in clock cycles derived from the `CLK_HZ` and `PULSE_MS` parameters.

Top module: `tpo_top`

## Requirements
- R1: After reset, `rst_out_n`, `intr_clr_n` and `bypass_n` are 1, and registers 0 (control), 1 (arming) and 2 (intrusion) all read 0x00.
- R2: With arming bit 7 of register 1 set, writing 1 to bit 4 of register 0 drives `rst_out_n` low from the cycle after the write for exactly TICKS = CLK_HZ/1000*PULSE_MS consecutive cycles.
- R3: Bit 4 of register 0 reads 1 while the reset pulse is running and 0 after it ends, with no software write needed to clear it.
- R4: If arming bit 7 of register 1 is 0 when bit 4 of register 0 is written, `rst_out_n` stays 1 and bit 4 reads 0 again two cycles after the write.
- R5: Writing 1 to bit 7 of register 2 drives `intr_clr_n` low for exactly TICKS cycles. Bit 7 reads 1 during the pulse and 0 after it.
- R6: Writing a trigger bit again while its pulse is running neither restarts nor lengthens the pulse.
- R7: Writes to other bits of the same register during a pulse, including writing 0 to the trigger bit, do not shorten or cancel the pulse.
- R8: `bypass_n` equals the inverse of bit 6 of register 0. It updates on the second clock edge after the write.
- R9: Non-trigger bits of registers 0 to 2 store and read back what was written. Register 3 reads 0x00. `rd_data` shows the register selected by `addr` one cycle after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rst_out_n | output | 1 | Active-low master reset pulse |
| intr_clr_n | output | 1 | Active-low intrusion-latch clear pulse |
| bypass_n | output | 1 | Active-low power-switch bypass drive |

## Verification
The bench builds the block with CLK_HZ=1000 and PULSE_MS=20. This turns the 20 ms low time into 20 cycles, so each complete pulse can be counted edge by edge in a short run. With pulses that short, the bench can place a retrigger write or an unrelated write partway through a pulse. It can then confirm that the pulse still ends on its exact cycle. It also lets one run cover the unarmed request and the readback of each self-clearing bit before and after its pulse.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam logic [AW-1:0] A_CTL = 2'd0;
  localparam logic [AW-1:0] A_ARM = 2'd1;
  localparam logic [AW-1:0] A_ICL = 2'd2;
  localparam int RST_TRIG_BIT = 4;
  localparam int BYP_BIT      = 6;
  localparam int ARM_BIT      = 7;
  localparam int ICL_TRIG_BIT = 7;
endpackage

// File: rtl/tpo_timer.sv
module tpo_timer #(
  parameter int TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic pin_n
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(TICKS - 1);
    end
  end

  assign pin_n = ~busy;

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy); // R2
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt) == '0); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (busy && start && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R6
endmodule

// File: rtl/tpo_regs.sv
module tpo_regs
  import tpo_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] arm_q,
  output logic [DW-1:0] icl_q
);
  localparam logic [DW-1:0] CTL_KEEP = ~(DW'(1) << RST_TRIG_BIT);
  localparam logic [DW-1:0] ICL_KEEP = ~(DW'(1) << ICL_TRIG_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      arm_q <= '0;
      icl_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTL:   ctl_q <= wr_data & CTL_KEEP;
        A_ARM:   arm_q <= wr_data;
        A_ICL:   icl_q <= wr_data & ICL_KEEP;
        default: ;
      endcase
    end
  end

  AST_TRIG_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[RST_TRIG_BIT] && !icl_q[ICL_TRIG_BIT]); // R9
endmodule

// File: rtl/tpo_top.sv
module tpo_top
  import tpo_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int PULSE_MS = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          rst_out_n,
  output logic          intr_clr_n,
  output logic          bypass_n
);
  localparam int TICKS = (CLK_HZ / 1000) * PULSE_MS;

  logic [DW-1:0] ctl_q, arm_q, icl_q;
  logic rst_req, rst_go, icl_go, rst_busy, icl_busy, pend;
  logic [DW-1:0] rd_next;

  tpo_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctl_q(ctl_q), .arm_q(arm_q), .icl_q(icl_q)
  );

  assign rst_req = wr_en && addr == A_CTL && wr_data[RST_TRIG_BIT];
  assign rst_go  = rst_req && arm_q[ARM_BIT];
  assign icl_go  = wr_en && addr == A_ICL && wr_data[ICL_TRIG_BIT];

  tpo_timer #(.TICKS(TICKS)) u_rst_tmr (
    .clk(clk), .rst(rst), .start(rst_go), .busy(rst_busy), .pin_n(rst_out_n)
  );

  tpo_timer #(.TICKS(TICKS)) u_icl_tmr (
    .clk(clk), .rst(rst), .start(icl_go), .busy(icl_busy), .pin_n(intr_clr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= rst_req && !arm_q[ARM_BIT] && !rst_busy;
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      A_CTL: begin
        rd_next = ctl_q;
        rd_next[RST_TRIG_BIT] = rst_busy | pend;
      end
      A_ARM: rd_next = arm_q;
      A_ICL: begin
        rd_next = icl_q;
        rd_next[ICL_TRIG_BIT] = icl_busy;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      bypass_n <= 1'b1;
    end else begin
      rd_data  <= rd_next;
      bypass_n <= ~ctl_q[BYP_BIT];
    end
  end

  AST_ARM_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_busy) |-> $past(arm_q[ARM_BIT])); // R4
  AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pend |=> !pend); // R4
  AST_ICL_START: assert property (@(posedge clk) disable iff (rst)
    $fell(intr_clr_n) |-> $past(icl_go)); // R5
endmodule

// File: tb/sim_tpo_top.sv
module sim_tpo_top;
  localparam int CLK_HZ = 1000;
  localparam int PMS    = 20;
  localparam int TICKS  = CLK_HZ / 1000 * PMS;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic rst_out_n, intr_clr_n, bypass_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tpo_top #(.CLK_HZ(CLK_HZ), .PULSE_MS(PMS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .rst_out_n(rst_out_n), .intr_clr_n(intr_clr_n),
    .bypass_n(bypass_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; wr_en = 1'b0;
    step();
    d = rd_data;
  endtask

  function automatic logic pin(int sel);
    return (sel == 0) ? rst_out_n : intr_clr_n;
  endfunction

  // Start a pulse, optionally inject a write at cycle 5, count low cycles.
  task automatic run_pulse(int sel, logic [1:0] ta, logic [7:0] td, bit inj,
                           logic [1:0] ia, logic [7:0] id, output int lows);
    lows = 0;
    wr(ta, td);
    for (int c = 0; c < TICKS + 8; c++) begin
      if (pin(sel) == 1'b0) lows++;
      if (inj && c == 5) wr(ia, id);
      else step();
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 rst_out_n", rst_out_n, 1);
    check("R1 intr_clr_n", intr_clr_n, 1);
    check("R1 bypass_n", bypass_n, 1);
    rd(0, d); check("R1 reg0", d, 0);
    rd(1, d); check("R1 reg1", d, 0);
    rd(2, d); check("R1 reg2", d, 0);
  endtask

  task automatic t_storage();
    logic [7:0] d;
    wr(0, 8'h2B); wr(1, 8'h15); wr(2, 8'h05);
    rd(0, d); check("R9 reg0", d, 8'h2B);
    rd(1, d); check("R9 reg1", d, 8'h15);
    rd(2, d); check("R9 reg2", d, 8'h05);
    rd(3, d); check("R9 reg3", d, 8'h00);
    check("R2 no pulse from storage", rst_out_n, 1);
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
  endtask

  task automatic t_unarmed();
    logic [7:0] d;
    int lows = 0;
    wr(1, 8'h00);
    wr(0, 8'h10);
    for (int c = 0; c < TICKS + 3; c++) begin
      if (!rst_out_n) lows++;
      step();
    end
    check("R4 unarmed low cycles", lows, 0);
    rd(0, d); check("R4 bit4 cleared", d[4], 0);
  endtask

  task automatic t_rst_pulse();
    int lows;
    wr(1, 8'h80);
    run_pulse(0, 0, 8'h10, 0, 0, 0, lows);
    check("R2 reset pulse length", lows, TICKS);
    check("R2 pin released", rst_out_n, 1);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(0, 8'h10);
    rd(0, d); check("R3 bit4 during pulse", d[4], 1);
    for (int c = 0; c < TICKS + 2; c++) step();
    rd(0, d); check("R3 bit4 self-cleared", d[4], 0);
  endtask

  task automatic t_icl();
    logic [7:0] d;
    int lows;
    run_pulse(1, 2, 8'h80, 0, 0, 0, lows);
    check("R5 intrusion pulse length", lows, TICKS);
    wr(2, 8'h80);
    rd(2, d); check("R5 bit7 during pulse", d[7], 1);
    for (int c = 0; c < TICKS + 2; c++) step();
    rd(2, d); check("R5 bit7 self-cleared", d[7], 0);
  endtask

  task automatic t_retrigger();
    int lows;
    run_pulse(0, 0, 8'h10, 1, 0, 8'h10, lows);
    check("R6 reset retrigger length", lows, TICKS);
    run_pulse(1, 2, 8'h80, 1, 2, 8'h80, lows);
    check("R6 intrusion retrigger length", lows, TICKS);
  endtask

  task automatic t_other_bits();
    int lows;
    run_pulse(0, 0, 8'h10, 1, 0, 8'h40, lows);
    check("R7 reset pulse with other write", lows, TICKS);
    check("R7 bypass set mid-pulse", bypass_n, 0);
    run_pulse(1, 2, 8'h80, 1, 2, 8'h03, lows);
    check("R7 intrusion pulse with other write", lows, TICKS);
    wr(0, 8'h00); step();
  endtask

  task automatic t_bypass();
    wr(0, 8'h40);
    check("R8 not yet updated", bypass_n, 1);
    step();
    check("R8 bypass low", bypass_n, 0);
    wr(0, 8'h00); step();
    check("R8 bypass high", bypass_n, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_storage();
    t_unarmed();
    t_rst_pulse();
    t_readback();
    t_icl();
    t_retrigger();
    t_other_bits();
    t_bypass();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule